// File: doc/BRIEF.md
# Tagged Serial Receive Queue

This block is the receive half of an asynchronous serial port. It watches a single serial input line and uses a tick at sixteen times the bit rate to find the start of each character. It then samples eight data bits, least significant first, and an optional parity bit. It checks the stop bit and stores the character in a small queue. Every stored entry is twelve bits wide and carries its own error flags, so software always sees a character together with the conditions under which it arrived.

The consumer reads the oldest entry from a show-ahead port and acknowledges it with a one-cycle read strobe. A separate four-bit status view shows the flags of the entry at the head of the queue. A queue-enable input chooses between the full multi-entry queue and a single holding slot.

A line that stays low through a whole character and one more bit time counts as a break. A break stores one zero entry and then stops reception until the line returns high. A character that completes while storage is full is dropped, and the stored entries are left as they are. The loss is signalled as an overrun.

Top module: `serial_rx_tagq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rx_avail` is 0 and nothing is stored.
- R2: A frame is one low start bit, eight data bits sent LSB first, and a high stop bit. It is stored as one entry with the data in bits 7:0 and bits 11:8 zero. The start bit is confirmed half a bit after the falling edge, and each bit is sampled at its centre (16 ticks of `baud_tick16` per bit).
- R3: A low pulse on `rxd` shorter than half a bit time stores nothing. The next proper frame is received normally.
- R4: When `parity_en` is 1, a parity bit follows the data. The expected value depends on the mode. With `parity_stick`=0 and `parity_even`=1 it makes the count of ones across data and parity even. With `parity_stick`=0 and `parity_even`=0 it makes that count odd. With `parity_stick`=1 it is the inverse of `parity_even`. A mismatch sets bit 9 of the entry.
- R5: A low stop bit on a frame that had at least one high data or parity bit sets bit 8 and keeps the data. Reception resumes once the line has returned high.
- R6: If the line stays low from the start bit through the stop bit and one more bit time, exactly one entry `0x400` is stored (bit 10 set, data zero). Nothing more is stored until the line goes high and a new start bit arrives.
- R7: With `fifo_en`=1, up to DEPTH entries are held in arrival order. `rd_data` shows the oldest one, and a cycle with `rd_en`=1 while `rx_avail`=1 removes it.
- R8: With `fifo_en`=0, only one entry is held. A character that completes while it is occupied is not stored.
- R9: A character that completes while storage is full is discarded, and the stored entries keep their order and values. From then on bit 11 of `rd_data` reads 1 on every read until the next character is stored. That character's entry carries bit 11 set, and later entries have bit 11 clear.
- R10: `head_flags` always equals bits 11:8 of `rd_data`, the flags of the head entry.
- R11: `rx_avail` stays low from one cycle to the next unless a character is being stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idles high |
| fifo_en | input | 1 | 1: multi-entry queue, 0: single holding slot |
| parity_en | input | 1 | A parity bit follows the data |
| parity_even | input | 1 | Even-parity select |
| parity_stick | input | 1 | Stick-parity select |
| rd_en | input | 1 | Removes the head entry |
| rd_data | output | 12 | Head entry: {overrun, break, parity err, framing err, data[7:0]} |
| rx_avail | output | 1 | At least one entry is stored |
| head_flags | output | 4 | Flags of the head entry, {overrun, break, parity, framing} |

## Verification
The bench builds the block with DEPTH=4 and the default 16x oversampling, and it pulses the tick every fourth clock. With a depth of four, the full-queue overrun path is reached after only five characters. The same drop-and-tag sequence is then repeated in single-slot mode. The short tick interval keeps a break, which needs more than eleven bit times of low line, and all four parity modes within a short run.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = 12;
  localparam int FE_BIT  = 8;
  localparam int PE_BIT  = 9;
  localparam int BE_BIT  = 10;
  localparam int OE_BIT  = 11;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRK, RX_HOLD
  } rx_state_e;

  // expected parity bit for the selected mode
  function automatic logic parity_expect(input logic [DATA_W-1:0] d,
                                         input logic even_sel,
                                         input logic stick_sel);
    if (stick_sel) return ~even_sel;
    return even_sel ? ^d : ~^d;
  endfunction

  // entry without the overrun bit: {break, parity, framing, data}
  function automatic logic [ENTRY_W-2:0] pack_entry(input logic brk,
                                                    input logic par_err,
                                                    input logic frm_err,
                                                    input logic [DATA_W-1:0] d);
    return {brk, par_err, frm_err, d};
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx,
  input  logic                 par_en,
  input  logic                 par_even,
  input  logic                 par_stick,
  output logic                 push_o,
  output logic [ENTRY_W-2:0]   entry_o
);
  localparam int PW = $clog2(OSR);
  localparam int NW = $clog2(DATA_W);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(OSR / 2 - 1);
  localparam logic [NW-1:0] NB_LAST = NW'(DATA_W - 1);

  rx_state_e         state;
  logic [PW-1:0]     ph;
  logic [NW-1:0]     nbit;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              low_all;
  logic              pe_now;

  always_comb pe_now = par_en && (par_bit != parity_expect(shreg, par_even, par_stick));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      ph      <= '0;
      nbit    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      low_all <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rx) begin
              state <= RX_START;
              ph    <= '0;
            end
          end
          RX_START: begin
            if (ph == PH_MID) begin
              ph <= '0;
              if (!rx) begin
                state   <= RX_DATA;
                nbit    <= '0;
                low_all <= 1'b1;
                par_bit <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          RX_DATA: begin
            if (ph == PH_LAST) begin
              ph    <= '0;
              shreg <= {rx, shreg[DATA_W-1:1]};
              if (rx) low_all <= 1'b0;
              nbit  <= nbit + 1'b1;
              if (nbit == NB_LAST) state <= par_en ? RX_PAR : RX_STOP;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          RX_PAR: begin
            if (ph == PH_LAST) begin
              ph      <= '0;
              par_bit <= rx;
              if (rx) low_all <= 1'b0;
              state   <= RX_STOP;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          RX_STOP: begin
            if (ph == PH_LAST) begin
              ph <= '0;
              if (rx) begin
                push_o  <= 1'b1;
                entry_o <= pack_entry(1'b0, pe_now, 1'b0, shreg);
                state   <= RX_IDLE;
              end else if (!low_all) begin
                push_o  <= 1'b1;
                entry_o <= pack_entry(1'b0, pe_now, 1'b1, shreg);
                state   <= RX_HOLD;
              end else begin
                state <= RX_BRK;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          RX_BRK: begin
            if (rx) begin
              push_o  <= 1'b1;
              entry_o <= pack_entry(1'b0, pe_now, 1'b1, shreg);
              state   <= RX_IDLE;
            end else if (ph == PH_LAST) begin
              push_o  <= 1'b1;
              entry_o <= pack_entry(1'b1, 1'b0, 1'b0, '0);
              state   <= RX_HOLD;
            end else begin
              ph <= ph + 1'b1;
            end
          end
          RX_HOLD: begin
            if (rx) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_tag_store.sv
module rx_tag_store
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [ENTRY_W-2:0] din,
  input  logic               fifo_en,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               avail,
  output logic               full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wptr, rptr;
  logic [CW-1:0]      count;
  logic [CW-1:0]      limit;
  logic               ovr_pend;
  logic               do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign limit  = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full_o = (count >= limit);
  assign do_wr  = push && !full_o;
  assign do_rd  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= {ovr_pend, din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      ovr_pend <= 1'b0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (!do_wr && do_rd) count <= count - 1'b1;
      if (push && full_o) ovr_pend <= 1'b1;
      else if (do_wr)     ovr_pend <= 1'b0;
    end
  end

  assign head  = {mem[rptr][OE_BIT] | ovr_pend, mem[rptr][ENTRY_W-2:0]};
  assign avail = (count != '0);
endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
  import serial_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baud_tick16,
  input  logic               rxd,
  input  logic               fifo_en,
  input  logic               parity_en,
  input  logic               parity_even,
  input  logic               parity_stick,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rx_avail,
  output logic [3:0]         head_flags
);
  logic               rx_s;
  logic               frm_push;
  logic [ENTRY_W-2:0] frm_entry;
  logic               q_full;

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rx_s)
  );

  rx_framer #(.OSR(OSR)) framer_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick16),
    .rx       (rx_s),
    .par_en   (parity_en),
    .par_even (parity_even),
    .par_stick(parity_stick),
    .push_o   (frm_push),
    .entry_o  (frm_entry)
  );

  rx_tag_store #(.DEPTH(DEPTH)) store_i (
    .clk    (clk),
    .rst    (rst),
    .push   (frm_push),
    .din    (frm_entry),
    .fifo_en(fifo_en),
    .pop    (rd_en),
    .head   (rd_data),
    .avail  (rx_avail),
    .full_o (q_full)
  );

  assign head_flags = rd_data[OE_BIT:FE_BIT];
endmodule

// File: rtl/serial_rx_tagq_chk.sv
module serial_rx_tagq_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic        rx_avail,
  input logic [11:0] rd_data,
  input logic        frm_push,
  input logic        q_full
);
  // R1
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> !rx_avail);

  // R7: head entry does not move without a read
  p_head_hold_r7: assert property (@(posedge clk) disable iff (rst)
    rx_avail && !rd_en |=> rx_avail && $stable(rd_data[10:0]));

  // R6: a break entry is a bare zero character
  p_break_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rx_avail && rd_data[10] |-> (rd_data[9:0] == 10'h000));

  // R9: a store attempt into full storage raises the overrun indication
  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (rst)
    q_full && frm_push |=> rd_data[11]);

  // R11
  p_empty_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rx_avail && !frm_push |=> !rx_avail);
endmodule

bind serial_rx_tagq serial_rx_tagq_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .rx_avail(rx_avail),
  .rd_data (rd_data),
  .frm_push(frm_push),
  .q_full  (q_full)
);

// File: tb/serial_rx_tagq_tb_top.sv
module serial_rx_tagq_tb_top;
  localparam int DEPTH    = 4;
  localparam int OSR      = 16;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = OSR * TICK_DIV;

  logic        clk = 1'b0;
  logic        rst, baud_tick16, rxd, fifo_en, parity_en, parity_even, parity_stick, rd_en;
  logic [11:0] rd_data;
  logic        rx_avail;
  logic [3:0]  head_flags;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  bit    mon_on = 0;
  logic [11:0] expq[$];
  string       tagq[$];

  serial_rx_tagq #(.DEPTH(DEPTH), .OSR(OSR)) dut_i (
    .clk(clk), .rst(rst), .baud_tick16(baud_tick16), .rxd(rxd),
    .fifo_en(fifo_en), .parity_en(parity_en), .parity_even(parity_even),
    .parity_stick(parity_stick), .rd_en(rd_en), .rd_data(rd_data),
    .rx_avail(rx_avail), .head_flags(head_flags)
  );

  initial forever #10 clk = ~clk;

  initial begin
    baud_tick16 = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      baud_tick16 = 1'b1;
      @(negedge clk);
      baud_tick16 = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic logic par_bit_for(input logic [7:0] d);
    if (parity_stick) return !parity_even;
    return parity_even ? ^d : ~^d;
  endfunction

  task automatic line(input int nbits, input logic v);
    rxd = v;
    repeat (nbits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stopb);
    line(1, 1'b0);
    for (int i = 0; i < 8; i++) line(1, d[i]);
    if (parity_en) line(1, par_bit_for(d) ^ bad_par);
    line(1, stopb);
    line(2, 1'b1);
  endtask

  task automatic expect_entry(input logic [11:0] e, input string tag);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk({tag, " all expected entries seen"}, 12'(expq.size()), 12'h000);
  endtask

  // monitor: pops expected entries and compares with the head
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rx_avail === 1'b1) begin
        if (expq.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL unexpected entry actual=%03h expected=none", rd_data);
        end else begin
          logic [11:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(t, rd_data, e);
          chk({t, " R10 head_flags"}, {8'h00, head_flags}, {8'h00, e[11:8]});
        end
        do_read();
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] ch [7];
    rst = 1'b1; rxd = 1'b1; rd_en = 1'b0; fifo_en = 1'b1;
    parity_en = 1'b0; parity_even = 1'b0; parity_stick = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 avail after reset", {11'h0, rx_avail}, 12'h000);
    repeat (BIT_CLKS) @(negedge clk);
    chk("R1 idle line stores nothing", {11'h0, rx_avail}, 12'h000);

    mon_on = 1;
    // R2: plain frames
    expect_entry(12'h055, "R2 0x55"); send(8'h55, 1'b0, 1'b1);
    expect_entry(12'h0A3, "R2 0xA3"); send(8'hA3, 1'b0, 1'b1);
    expect_entry(12'h000, "R2 0x00"); send(8'h00, 1'b0, 1'b1);
    expect_entry(12'h0FF, "R2 0xFF"); send(8'hFF, 1'b0, 1'b1);
    expect_entry(12'h081, "R2 0x81"); send(8'h81, 1'b0, 1'b1);

    // R3: short glitch
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    line(2, 1'b1);
    expect_entry(12'h03C, "R3 after glitch"); send(8'h3C, 1'b0, 1'b1);
    drain("R3");

    // R4: parity modes
    parity_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      parity_stick = m[1];
      parity_even  = m[0];
      expect_entry(12'h096, "R4 parity good"); send(8'h96, 1'b0, 1'b1);
      expect_entry(12'h207, "R4 parity bad");  send(8'h07, 1'b1, 1'b1);
    end
    drain("R4");
    parity_en = 1'b0; parity_stick = 1'b0; parity_even = 1'b0;

    // R5: framing error then recovery
    expect_entry(12'h15A, "R5 framing error"); send(8'h5A, 1'b0, 1'b0);
    expect_entry(12'h021, "R5 recovery");      send(8'h21, 1'b0, 1'b1);

    // R6: break
    expect_entry(12'h400, "R6 break entry");
    line(13, 1'b0);
    line(2, 1'b1);
    expect_entry(12'h042, "R6 after break"); send(8'h42, 1'b0, 1'b1);
    drain("R6");

    // R7 / R9: queue overrun
    mon_on = 0;
    ch[0] = 8'h11; ch[1] = 8'h22; ch[2] = 8'h33; ch[3] = 8'h44;
    ch[4] = 8'h55; ch[5] = 8'h66; ch[6] = 8'h77;
    for (int i = 0; i < 5; i++) send(ch[i], 1'b0, 1'b1);
    chk("R9 head shows overrun", rd_data, {4'h8, ch[0]});
    chk("R10 head_flags overrun", {8'h00, head_flags}, 12'h008);
    for (int i = 0; i < 4; i++) begin
      chk("R7 order with overrun pending", rd_data, {4'h8, ch[i]});
      do_read();
    end
    chk("R9 dropped char not stored", {11'h0, rx_avail}, 12'h000);
    mon_on = 1;
    expect_entry({4'h8, ch[5]}, "R9 next entry tagged"); send(ch[5], 1'b0, 1'b1);
    expect_entry({4'h0, ch[6]}, "R9 tag cleared");       send(ch[6], 1'b0, 1'b1);
    drain("R9");

    // R8: single slot
    mon_on = 0;
    fifo_en = 1'b0;
    send(8'hA1, 1'b0, 1'b1);
    send(8'hB2, 1'b0, 1'b1);
    chk("R8 slot keeps first char", rd_data, 12'h8A1);
    do_read();
    chk("R8 second char dropped", {11'h0, rx_avail}, 12'h000);
    mon_on = 1;
    expect_entry(12'h8C3, "R8 next entry tagged"); send(8'hC3, 1'b0, 1'b1);
    expect_entry(12'h0D4, "R8 clean entry");       send(8'hD4, 1'b0, 1'b1);
    drain("R8");

    done = 1;
    summary();
    $finish;
  end
endmodule